// File: doc/BRIEF.md
# Virtual Processor Run/Stop Controller

This block holds the run state of every virtual processor (VP) inside one core and drives a run-enable line for each of them. Software changes that state through a small memory-mapped register window. Two write-only bitmask registers act on the state. Writing a mask to the start register puts each VP whose bit is 1 into the run state. Writing a mask to the halt register suspends each VP whose bit is 1. A third register is read-only and returns the current run state, one bit per VP.

The reset state depends on a strap input, `solo_boot`, which is sampled while reset is asserted. When the strap is high, only VP0 leaves reset running, and software wakes the other VPs later. When the strap is low, every VP leaves reset running. The register window uses one access per cycle. A write takes effect on the next rising clock edge. Read data is combinational from the address and the stored state.

Top module: `vp_runctl`

## Requirements
- R1: With `solo_boot`=1 during a synchronous active-low reset, `vp_run_en` is 1 for VP0 only once reset is released, and the status register reads 0x1 (with 4 VPs).
- R2: With `solo_boot`=0 during reset, every bit of `vp_run_en` is 1 once reset is released.
- R3: A write to the start register (offset 0x0) sets to running each VP whose bit in `reg_wdata` is 1. VPs whose bit is 0 keep their state.
- R4: A write to the halt register (offset 0x8) suspends each VP whose bit in `reg_wdata` is 1. VPs whose bit is 0 keep their state.
- R5: While `reg_addr` is the status offset 0x10, `reg_rdata` bit i equals the run state of VP i, and all bits at or above NUM_VP read 0.
- R6: Reads at offset 0x0, offset 0x8 or any unmapped offset return 0.
- R7: Writes to the status offset or to any unmapped offset leave every VP's state unchanged.
- R8: A write changes `vp_run_en` at the first rising edge after it is presented. In a cycle with no write, the state holds.
- R9: Bits of `reg_wdata` at positions NUM_VP and above have no effect on any VP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| solo_boot | input | 1 | Strap sampled during reset: 1 = only VP0 runs, 0 = all VPs run |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | DATA_W (32) | Write data bitmask |
| reg_rdata | output | DATA_W (32) | Combinational read data |
| vp_run_en | output | NUM_VP (4) | Run enable, one bit per VP |

## Verification
The bench first writes masks with mixed 0 and 1 bits. A design that cleared or set the VPs whose bit is 0 would show a wrong run state at the next status read. It then writes to the status offset and to unmapped offsets with all-ones and all-zeros data. A decoder that matched too few address bits would start or halt VPs on those writes. It reads back the start and halt offsets, where a lazy read multiplexer would return stale data or the state. It drives all-ones data whose upper bits are set, where a design that sliced the wrong field would act on them. Finally, it applies both reset strap settings. A design that ignored the strap, or sampled it outside reset, would come up with the wrong set of VPs running.

// File: rtl/vp_runctl_pkg.sv
// Package: shared types and register offsets for the VP run/stop controller.
// Assumes byte offsets fit in the address width chosen by the top module.
package vp_runctl_pkg;

    // Byte offsets of the three registers in the window
    localparam int unsigned OFS_START  = 'h00;
    localparam int unsigned OFS_HALT   = 'h08;
    localparam int unsigned OFS_STATUS = 'h10;

    // Decoded register selected by the current address
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_START  = 2'd1,
        SEL_HALT   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/vp_runctl_decode.sv
// Module: address decoder. It turns the address and the write strobe into a
// register select plus per-VP set and clear masks.
// Assumes one access per cycle and full decoding of every address bit.
module vp_runctl_decode
    import vp_runctl_pkg::*;
#(
    parameter int unsigned NUM_VP = 4,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output reg_sel_e          sel_o,
    output logic [NUM_VP-1:0] set_o,
    output logic [NUM_VP-1:0] clr_o
);

    localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(OFS_START);
    localparam logic [ADDR_W-1:0] A_HALT   = ADDR_W'(OFS_HALT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    logic unused_wdata;

    // Parity of the whole write word; only the low NUM_VP bits matter
    assign unused_wdata = ^wdata_i;

    // Match the address against the three register offsets
    always_comb begin
        unique case (addr_i)
            A_START:  sel_o = SEL_START;
            A_HALT:   sel_o = SEL_HALT;
            A_STATUS: sel_o = SEL_STATUS;
            default:  sel_o = SEL_NONE;
        endcase
    end

    // Build the set and clear masks from the low bits of the write word
    always_comb begin
        set_o = '0;
        clr_o = '0;
        if (we_i && sel_o == SEL_START) set_o = wdata_i[NUM_VP-1:0];
        if (we_i && sel_o == SEL_HALT)  clr_o = wdata_i[NUM_VP-1:0];
    end

endmodule

// File: rtl/vp_runctl_cell.sv
// Module: run-state flop for one VP.
// Assumes a synchronous active-low reset; clear has priority over set.
module vp_runctl_cell #(
    parameter bit BOOT_LEADER = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic solo_boot,
    input  logic set_i,
    input  logic clr_i,
    output logic run_o
);

    logic run_q;

    // Hold the run state: reset value from the strap, then clear beats set
    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= BOOT_LEADER | ~solo_boot;
        else if (clr_i) run_q <= 1'b0;
        else if (set_i) run_q <= 1'b1;
    end

    assign run_o = run_q;

    assert_halt_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !run_o);
    assert_start_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> run_o);
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(run_o));

endmodule

// File: rtl/vp_runctl_readback.sv
// Module: read multiplexer. It returns the run state at the status offset
// and zero everywhere else.
// Assumes NUM_VP <= DATA_W.
module vp_runctl_readback
    import vp_runctl_pkg::*;
#(
    parameter int unsigned NUM_VP = 4,
    parameter int unsigned DATA_W = 32
) (
    input  reg_sel_e          sel_i,
    input  logic [NUM_VP-1:0] run_i,
    output logic [DATA_W-1:0] rdata_o
);

    // Place the run state in the low bits for status reads only
    always_comb begin
        rdata_o = '0;
        if (sel_i == SEL_STATUS) rdata_o[NUM_VP-1:0] = run_i;
    end

endmodule

// File: rtl/vp_runctl.sv
// Module: top level of the per-VP run/stop controller. It connects the
// decoder, one state cell per VP and the read multiplexer.
// Assumes NUM_VP <= DATA_W and that offset 0x10 fits in ADDR_W bits.
module vp_runctl
    import vp_runctl_pkg::*;
#(
    parameter int unsigned NUM_VP = 4,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              solo_boot,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_VP-1:0] vp_run_en
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    reg_sel_e          sel;
    logic [NUM_VP-1:0] set_mask;
    logic [NUM_VP-1:0] clr_mask;

    vp_runctl_decode #(.NUM_VP(NUM_VP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .addr_i  (reg_addr),
        .we_i    (reg_we),
        .wdata_i (reg_wdata),
        .sel_o   (sel),
        .set_o   (set_mask),
        .clr_o   (clr_mask)
    );

    // One state cell per VP; VP0 is the one kept running by the strap
    for (genvar g = 0; g < NUM_VP; g++) begin : g_cell
        vp_runctl_cell #(.BOOT_LEADER(g == 0)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .solo_boot (solo_boot),
            .set_i     (set_mask[g]),
            .clr_i     (clr_mask[g]),
            .run_o     (vp_run_en[g])
        );
    end

    vp_runctl_readback #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_readback (
        .sel_i   (sel),
        .run_i   (vp_run_en),
        .rdata_o (reg_rdata)
    );

    assert_status_mirrors_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STATUS) |-> (reg_rdata[NUM_VP-1:0] == vp_run_en));
    assert_other_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != A_STATUS) |-> (reg_rdata == '0));
    assert_status_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_STATUS) |=> $stable(vp_run_en));

endmodule

// File: tb/sim_vp_runctl.sv
module sim_vp_runctl;

    localparam int NV = 4;
    localparam int AW = 8;
    localparam int DW = 32;

    typedef struct {
        logic [DW-1:0] rdata;
        logic [NV-1:0] run;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          solo_boot = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NV-1:0] vp_run_en;

    int checks = 0;
    int errors = 0;
    logic [NV-1:0] model = '0;
    exp_t q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    vp_runctl #(.NUM_VP(NV), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .solo_boot(solo_boot), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vp_run_en(vp_run_en)
    );

    // Driver: apply one access, push what the outputs must show this cycle, update model
    task automatic op(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] d,
                      input string tag);
        exp_t e;
        @(posedge clk);
        #2;
        reg_addr  = a;
        reg_we    = we;
        reg_wdata = d;
        e.run   = model;
        e.rdata = (a == 8'h10) ? DW'(model) : '0;
        e.tag   = tag;
        q.push_back(e);
        if (we && a == 8'h00) model = model | d[NV-1:0];
        if (we && a == 8'h08) model = model & ~d[NV-1:0];
    endtask

    task automatic do_reset(input logic strap);
        @(posedge clk);
        #2;
        reg_we = 1'b0;
        rst_n = 1'b0;
        solo_boot = strap;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        model = strap ? NV'(1) : '1;
    endtask

    // Monitor: compare outputs mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (reg_rdata !== e.rdata || vp_run_en !== e.run) begin
                errors++;
                $display("FAIL %s rdata=%h run=%b expected rdata=%h run=%b",
                         e.tag, reg_rdata, vp_run_en, e.rdata, e.run);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        op(8'h10, 0, '0, "R1 solo reset state");
        op(8'h00, 1, 32'h0000_0004, "R3 start VP2");
        op(8'h10, 0, '0, "R3 R8 VP2 now running, others kept");
        op(8'h00, 1, 32'h0000_0000, "R3 zero mask start");
        op(8'h10, 0, '0, "R3 zero mask no change");
        op(8'h08, 1, 32'h0000_0001, "R4 halt VP0");
        op(8'h10, 0, '0, "R4 VP0 halted, VP2 kept");
        op(8'h00, 1, 32'h0000_000A, "R3 start VP1 VP3");
        op(8'h00, 0, '0, "R6 read start offset");
        op(8'h08, 0, '0, "R6 read halt offset");
        op(8'h44, 0, '0, "R6 read unmapped offset");
        op(8'h10, 1, 32'h0000_0000, "R7 write zero to status");
        op(8'h10, 0, '0, "R7 status write inert");
        op(8'h90, 1, 32'hFFFF_FFFF, "R7 write unmapped 0x90");
        op(8'h18, 1, 32'hFFFF_FFFF, "R7 write unmapped 0x18");
        op(8'h10, 0, '0, "R7 unmapped writes inert");
        op(8'h08, 1, 32'hFFFF_FFF0, "R9 halt with upper bits only");
        op(8'h10, 0, '0, "R9 upper bits ignored");
        op(8'h08, 1, 32'hFFFF_FFFF, "R4 halt all");
        op(8'h10, 0, '0, "R4 all halted");
        op(8'h00, 1, 32'hFFFF_FFF0, "R9 start with upper bits only");
        op(8'h10, 0, '0, "R9 still all halted");
        op(8'h10, 0, '0, "R8 idle hold");
        do_reset(1'b0);
        op(8'h10, 0, '0, "R2 all-run reset state");
        op(8'h08, 1, 32'h0000_0006, "R4 halt VP1 VP2");
        op(8'h10, 0, '0, "R4 R5 status after halt");
        do_reset(1'b1);
        op(8'h10, 0, '0, "R1 solo reset after activity");
        op(8'h10, 0, '0, "R8 idle after reset");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule